// File: doc/BRIEF.md
# PWM Carrier Chopper

This block sits after a PWM generator and ahead of pulse-transformer gate drivers. A transformer cannot pass a long steady high level, so each high interval of the incoming PWM is broken up. While a lane's PWM input is high, the lane output carries a train of pulses. The train opens with a wide one-shot pulse whose width is programmed on its own, so that the gate charges quickly. A carrier follows, derived from the system clock, with a programmable frequency and duty. While the input is low, the output stays low.

The block has a parameterised number of identical lanes, two by default, for outputs A and B. All lanes share one set of configuration inputs. Each lane restarts its own one-shot and carrier phase on its own rising input edge. A bypass input makes every lane copy its PWM input to its output unchanged. Every output is registered, so the output follows the input by one clock cycle in both modes.

Top module: `pwm_chopper`

## Requirements
- R1: While `rst_n` is low, every bit of `chop_out` is 0.
- R2: With `bypass` low, a lane whose `pwm_in` bit was 0 in cycle t drives 0 on its `chop_out` bit in cycle t+1.
- R3: Let a lane's input be high in cycle t, with e the number of cycles since the input rose (e = 0 in the cycle of the rise). With `bypass` low, the output in cycle t+1 is high whenever e < 8*(shot_sel+1). This is the one-shot, where `shot_sel` is an unsigned 4-bit field.
- R4: The carrier period is 8*(div_sel+1) clock cycles, where `div_sel` is an unsigned 3-bit field. The period is divided into 8 slots of div_sel+1 cycles each. Slot number s = (e mod 8*(div_sel+1)) / (div_sel+1), so the carrier phase restarts at every rising edge of the lane input.
- R5: The carrier is high in slots s < H. The count H is duty_sel+1 for `duty_sel` values 0 to 6, and 7 for `duty_sel` = 7. This gives duties of 1/8 to 7/8.
- R6: With `bypass` low, the output in cycle t+1 equals pwm_in(t) AND (one-shot(t) OR carrier(t)).
- R7: With `bypass` high in cycle t, `chop_out` in cycle t+1 equals `pwm_in` in cycle t, whatever the other configuration inputs are.
- R8: Lanes are independent. Each lane's e counts from its own rising edge, and activity on one lane does not change the output of another.
- R9: The lane's e counter runs in either mode. Switching `bypass` off in the middle of a high interval continues the train at the current e, without starting a new one-shot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; also the carrier time base |
| rst_n | input | 1 | Asynchronous active-low reset |
| bypass | input | 1 | 1: copy inputs to outputs unchanged |
| div_sel | input | 3 | Carrier divider N; period 8*(N+1) clocks |
| duty_sel | input | 3 | Carrier duty code; high for min(D+1,7) eighths |
| shot_sel | input | 4 | One-shot width M; width 8*(M+1) clocks |
| pwm_in | input | LANES | PWM input per lane |
| chop_out | output | LANES | Chopped or bypassed output per lane |

## Verification
The bench sweeps every divider and duty code against short, medium and maximum one-shot widths.

- If the slot boundaries were wrong, pulses would land a cycle early or late.
- If the top duty code were not clamped, that lane would stay high for the whole period.
- If the one-shot were off by one unit, the first pulse would end 8 cycles early or late.

The bench also drives one-cycle gaps between high intervals, which catches a carrier or one-shot that fails to restart and continues from its old phase. It drives the two lanes out of step with each other, which exposes any counter shared between lanes. Bypass is toggled in the middle of a high interval, which catches a design that delays or alters the copied input.

// File: rtl/pwm_chop_pkg.sv
package pwm_chop_pkg;
    localparam int unsigned DIV_W_DEF     = 3;
    localparam int unsigned DUTY_W_DEF    = 3;
    localparam int unsigned SHOT_W_DEF    = 4;
    localparam int unsigned SHOT_UNIT_LG2 = 3;

    typedef enum logic {
        LANE_CHOP = 1'b0,
        LANE_PASS = 1'b1
    } lane_mode_e;
endpackage

// File: rtl/pwm_chop_carrier.sv
module pwm_chop_carrier #(
    parameter int unsigned DIV_W  = pwm_chop_pkg::DIV_W_DEF,
    parameter int unsigned DUTY_W = pwm_chop_pkg::DUTY_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic [DIV_W-1:0]  div_sel,
    input  logic [DUTY_W-1:0] duty_sel,
    output logic              carrier_hi
);
    // slot counter has DUTY_W bits, so a period holds 2**DUTY_W slots
    typedef struct packed {
        logic [DIV_W-1:0]  pre;
        logic [DUTY_W-1:0] slot;
    } car_t;

    car_t              st_d, st_q;
    logic [DIV_W-1:0]  pre_now;
    logic [DUTY_W-1:0] slot_now;
    logic [DUTY_W-1:0] slots_hi;
    logic              slot_end;

    always_comb begin
        st_d     = st_q;
        pre_now  = restart ? '0 : st_q.pre;
        slot_now = restart ? '0 : st_q.slot;
        // top code saturates one slot short of a full period
        slots_hi = (duty_sel == {DUTY_W{1'b1}}) ? duty_sel : duty_sel + DUTY_W'(1);
        carrier_hi = (slot_now < slots_hi);
        slot_end   = (pre_now == div_sel);
        st_d.pre   = slot_end ? '0 : pre_now + DIV_W'(1);
        st_d.slot  = slot_end ? slot_now + DUTY_W'(1) : slot_now;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/pwm_chop_oneshot.sv
module pwm_chop_oneshot #(
    parameter int unsigned SHOT_W = pwm_chop_pkg::SHOT_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic [SHOT_W-1:0] shot_sel,
    output logic              shot_hi
);
    import pwm_chop_pkg::*;

    localparam int unsigned OS_W = SHOT_W + SHOT_UNIT_LG2 + 1;

    typedef struct packed {
        logic [OS_W-1:0] cnt;
    } shot_t;

    shot_t           st_d, st_q;
    logic [OS_W-1:0] limit;
    logic [OS_W-1:0] cnt_now;

    always_comb begin
        st_d    = st_q;
        limit   = ({{(OS_W-SHOT_W){1'b0}}, shot_sel} + OS_W'(1)) << SHOT_UNIT_LG2;
        cnt_now = restart ? '0 : st_q.cnt;
        shot_hi = (cnt_now < limit);
        // saturate once the window has elapsed
        st_d.cnt = shot_hi ? cnt_now + OS_W'(1) : cnt_now;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/pwm_chop_lane.sv
module pwm_chop_lane #(
    parameter int unsigned DIV_W  = pwm_chop_pkg::DIV_W_DEF,
    parameter int unsigned DUTY_W = pwm_chop_pkg::DUTY_W_DEF,
    parameter int unsigned SHOT_W = pwm_chop_pkg::SHOT_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bypass,
    input  logic [DIV_W-1:0]  div_sel,
    input  logic [DUTY_W-1:0] duty_sel,
    input  logic [SHOT_W-1:0] shot_sel,
    input  logic              pwm_in,
    output logic              chop_out
);
    import pwm_chop_pkg::*;

    typedef struct packed {
        logic prev;
        logic out;
    } lane_t;

    lane_t      st_d, st_q;
    lane_mode_e mode;
    logic       restart;
    logic       carrier_hi;
    logic       shot_hi;

    pwm_chop_carrier #(
        .DIV_W  (DIV_W),
        .DUTY_W (DUTY_W)
    ) i_carrier (
        .clk        (clk),
        .rst_n      (rst_n),
        .restart    (restart),
        .div_sel    (div_sel),
        .duty_sel   (duty_sel),
        .carrier_hi (carrier_hi)
    );

    pwm_chop_oneshot #(
        .SHOT_W (SHOT_W)
    ) i_oneshot (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (restart),
        .shot_sel (shot_sel),
        .shot_hi  (shot_hi)
    );

    always_comb begin
        st_d    = st_q;
        mode    = lane_mode_e'(bypass);
        restart = pwm_in & ~st_q.prev;
        st_d.prev = pwm_in;
        unique case (mode)
            LANE_PASS: st_d.out = pwm_in;
            default:   st_d.out = pwm_in & (shot_hi | carrier_hi);
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign chop_out = st_q.out;
endmodule

// File: rtl/pwm_chopper.sv
module pwm_chopper #(
    parameter int unsigned LANES  = 2,
    parameter int unsigned DIV_W  = pwm_chop_pkg::DIV_W_DEF,
    parameter int unsigned DUTY_W = pwm_chop_pkg::DUTY_W_DEF,
    parameter int unsigned SHOT_W = pwm_chop_pkg::SHOT_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bypass,
    input  logic [DIV_W-1:0]  div_sel,
    input  logic [DUTY_W-1:0] duty_sel,
    input  logic [SHOT_W-1:0] shot_sel,
    input  logic [LANES-1:0]  pwm_in,
    output logic [LANES-1:0]  chop_out
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        pwm_chop_lane #(
            .DIV_W  (DIV_W),
            .DUTY_W (DUTY_W),
            .SHOT_W (SHOT_W)
        ) i_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .bypass   (bypass),
            .div_sel  (div_sel),
            .duty_sel (duty_sel),
            .shot_sel (shot_sel),
            .pwm_in   (pwm_in[g]),
            .chop_out (chop_out[g])
        );
    end
endmodule

// File: rtl/pwm_chopper_chk.sv
module pwm_chopper_chk #(
    parameter int unsigned LANES = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bypass,
    input logic [LANES-1:0] pwm_in,
    input logic [LANES-1:0] chop_out
);
    logic                  armed_q;
    logic [LANES-1:0]      prev_q;
    logic [LANES-1:0][7:0] run_q;
    logic [LANES-1:0][7:0] e_now;
    logic [LANES-1:0]      shot_min;

    always_comb begin
        for (int i = 0; i < LANES; i++) begin
            if (pwm_in[i] && prev_q[i]) begin
                e_now[i] = (run_q[i] == 8'hFF) ? 8'hFF : run_q[i] + 8'd1;
            end else begin
                e_now[i] = 8'd0;
            end
            shot_min[i] = pwm_in[i] & ~bypass & (e_now[i] < 8'd8);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
            prev_q  <= '0;
            run_q   <= '0;
        end else begin
            armed_q <= 1'b1;
            prev_q  <= pwm_in;
            run_q   <= e_now;
        end
    end

    always @(negedge clk) begin
        if (!rst_n) begin
            AST_RESET_CLEAR: assert (chop_out == '0); // R1
        end
    end

    for (genvar g = 0; g < LANES; g++) begin : g_prop
        AST_LOW_INPUT_LOW_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
            armed_q && !$past(bypass) && !$past(pwm_in[g]) |-> !chop_out[g]); // R2
        AST_BYPASS_COPY: assert property (@(posedge clk) disable iff (!rst_n)
            armed_q && $past(bypass) |-> chop_out[g] == $past(pwm_in[g])); // R7
        AST_FIRST_PULSE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
            armed_q && $past(shot_min[g]) |-> chop_out[g]); // R3
    end
endmodule

bind pwm_chopper pwm_chopper_chk #(.LANES(LANES)) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bypass   (bypass),
    .pwm_in   (pwm_in),
    .chop_out (chop_out)
);

// File: tb/test_pwm_chopper.sv
`timescale 1ns/1ps
module test_pwm_chopper;
    localparam int LANES = 2;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             bypass = 1'b0;
    logic [2:0]       div_sel = '0;
    logic [2:0]       duty_sel = '0;
    logic [3:0]       shot_sel = '0;
    logic [LANES-1:0] pwm_in = '0;
    logic [LANES-1:0] chop_out;

    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done = 1'b0;
    string tag = "R1";

    // configuration staged for the next drive slot
    logic       nx_bypass = 1'b0;
    logic [2:0] nx_div = '0;
    logic [2:0] nx_duty = '0;
    logic [3:0] nx_shot = '0;

    int e_m    [LANES];
    bit prev_m [LANES];
    bit exp_v  [LANES];
    bit exp_ok = 1'b0;

    always #10 clk = ~clk;

    pwm_chopper i_pwm_chopper (
        .clk      (clk),
        .rst_n    (rst_n),
        .bypass   (bypass),
        .div_sel  (div_sel),
        .duty_sel (duty_sel),
        .shot_sel (shot_sel),
        .pwm_in   (pwm_in),
        .chop_out (chop_out)
    );

    function automatic bit model(input int e, input bit pin, input bit byp,
                                 input int dv, input int dt, input int sh);
        int hi;
        int slot;
        if (byp) return pin;
        if (!pin) return 1'b0;
        hi   = (dt == 7) ? 7 : dt + 1;
        slot = (e % (8 * (dv + 1))) / (dv + 1);
        return (e < 8 * (sh + 1)) || (slot < hi);
    endfunction

    task automatic check_bit(input int lane, input bit act, input bit expv);
        n_cmp++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s lane %0d at %0t: actual %0b expected %0b", tag, lane, $time, act, expv);
        end
    endtask

    task automatic cycle(input logic [LANES-1:0] pin);
        @(negedge clk);
        if (exp_ok) begin
            for (int l = 0; l < LANES; l++) check_bit(l, chop_out[l], exp_v[l]);
        end
        bypass   = nx_bypass;
        div_sel  = nx_div;
        duty_sel = nx_duty;
        shot_sel = nx_shot;
        pwm_in   = pin;
        for (int l = 0; l < LANES; l++) begin
            if (pin[l]) e_m[l] = prev_m[l] ? e_m[l] + 1 : 0;
            prev_m[l] = pin[l];
            exp_v[l]  = model(e_m[l], pin[l], nx_bypass, int'(nx_div), int'(nx_duty), int'(nx_shot));
        end
        exp_ok = 1'b1;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        for (int l = 0; l < LANES; l++) begin
            e_m[l] = 0; prev_m[l] = 1'b0; exp_v[l] = 1'b0;
        end
        // R1: reset holds outputs low even with inputs high
        tag = "R1 reset";
        pwm_in = '1;
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            for (int l = 0; l < LANES; l++) check_bit(l, chop_out[l], 1'b0);
        end
        pwm_in = '0;
        @(negedge clk);
        rst_n = 1'b1;

        // R3 R4 R5 R6 R8: full divider and duty sweep, lanes out of step
        tag = "R3/R4/R5/R6 sweep";
        for (int dv = 0; dv < 8; dv++) begin
            for (int dt = 0; dt < 8; dt++) begin
                for (int si = 0; si < 3; si++) begin
                    nx_div  = 3'(dv);
                    nx_duty = 3'(dt);
                    nx_shot = (si == 0) ? 4'd0 : (si == 1) ? 4'd2 : 4'd15;
                    for (int t = 0; t < 146; t++) begin
                        cycle({(t >= 5 && t < 105), (t < 140)});
                    end
                end
            end
        end

        // R4 phase restart: pulses of rising length separated by one low cycle
        tag = "R4 restart";
        nx_div = 3'd3; nx_duty = 3'd2; nx_shot = 4'd0;
        for (int len = 1; len <= 45; len++) begin
            for (int t = 0; t < len; t++) cycle(2'b11);
            cycle(2'b00);
        end

        // R8: lane A held high while lane B toggles with odd gaps
        tag = "R8 lanes";
        nx_div = 3'd1; nx_duty = 3'd4; nx_shot = 4'd1;
        for (int t = 0; t < 300; t++) begin
            cycle({((t % 13) < 7), 1'b1});
        end
        cycle(2'b00);

        // R7: bypass copies an irregular pattern across config changes
        tag = "R7 bypass";
        nx_bypass = 1'b1;
        for (int k = 0; k < 400; k++) begin
            nx_div  = 3'(k % 8);
            nx_duty = 3'((k / 3) % 8);
            nx_shot = 4'(k % 16);
            cycle(2'(((k * 37) ^ (k >> 2)) & 3));
        end

        // R9: bypass released mid-interval continues the train
        tag = "R9 bypass release";
        nx_div = 3'd0; nx_duty = 3'd0; nx_shot = 4'd0;
        cycle(2'b00);
        for (int t = 0; t < 60; t++) begin
            if (t == 20) nx_bypass = 1'b0;
            cycle(2'b11);
        end

        // R2: low input after a train gives low output
        tag = "R2 low input";
        for (int t = 0; t < 20; t++) cycle(2'b00);
        cycle(2'b00);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule